// File: doc/BRIEF.md
# DS3 Multiframe Overhead Inserter

This block builds the transmit DS3 multiframe as a serial bit stream, one bit per line clock. A free-running position counter walks seven subframes of eight blocks. Each block is one overhead bit followed by 84 payload bits. When the counter is on a payload position, the block raises a request and takes the bit that the upstream mapper presents in that same cycle. When the counter is on an overhead position, it builds the overhead bit itself.

The overhead bits come from three places:
- Configuration inputs: the alarm level and a vector of C-bit values.
- Internal patterns: the framing bits and the multiframe alignment bits.
- A parity register: it holds the parity of the payload sent in the previous multiframe.

A nibble marker tells the mapper which payload bits start a 4-bit group. The marker is used when the payload is nibble aligned, which is the case for nibble-aligned cell mapping or for the convergence-frame mode. It stays off when the payload is bit aligned.

Top module: `ds3_mframe_gen`

## Requirements
- R1: The multiframe is 4760 line clocks long. `sof_o` is high for exactly one cycle per multiframe, in the cycle where `ser_o` carries the first overhead bit of subframe 1.
- R2: Overhead bits occur every 85th position. `pay_req_o` is high on exactly the 84 positions that follow each overhead bit, and it is low on every overhead position.
- R3: Within each subframe the eight overhead bits come in this order: leading bit, F1, C1, F2, C2, F3, C3, F4.
- R4: The framing bits F1, F2, F3 and F4 are driven as 1, 0, 0 and 1 in every subframe.
- R5: The leading bit of subframes 1 and 2 is the inverse of `alarm_i`. The leading bits of subframes 5, 6 and 7 are 0, 1 and 0.
- R6: The leading bit of subframes 3 and 4 is the XOR of all 4704 payload bits of the previous multiframe. It is 0 during the first multiframe after reset.
- R7: Bit Ck (k = 1..3) of subframe s (s = 1..7) is taken from `c_bits_i[(s-1)*3 + (k-1)]`.
- R8: When `nib_align_i` or `plcp_i` is high, `nib_o` is high together with `pay_req_o` on payload bits 1, 5, 9, ..., 81 of each block. When both are low, `nib_o` stays 0. `plcp_i` forces nibble alignment whatever the value of `nib_align_i`.
- R9: While `rst_ni` is low, `ser_o`, `sof_o`, `pay_req_o` and `nib_o` are 0. The first bit emitted after release is the first overhead bit of subframe 1.
- R10: `ser_o` shows, one clock later, the bit chosen in the current cycle: `pay_bit_i` when `pay_req_o` is high, otherwise the overhead bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pay_bit_i | input | 1 | Payload bit from the mapper, taken while pay_req_o is high |
| alarm_i | input | 1 | Remote alarm; the subframe 1 and 2 leading bits carry its inverse |
| c_bits_i | input | 21 | C-bit values, 3 per subframe |
| nib_align_i | input | 1 | Selects nibble-aligned payload |
| plcp_i | input | 1 | Convergence-frame mode; forces nibble alignment |
| ser_o | output | 1 | Serial DS3 line bit |
| sof_o | output | 1 | Start-of-multiframe marker, aligned with ser_o |
| pay_req_o | output | 1 | Payload bit due in this cycle |
| nib_o | output | 1 | Current payload bit starts a nibble |

## Verification
The multiframe wrap and the parity latch fall on the same clock edge. The last payload bit of subframe 7 is folded into the parity and stored while the counter returns to the first overhead bit. The bench provokes this by sending an all-zero multiframe, then an all-ones multiframe, then random payload. It judges the result on the subframe 3 and 4 leading bits of the following multiframe, which must equal the bench's own XOR of the bits it sent. A reset in mid-frame also checks that the stored parity falls back to 0.

// File: rtl/ds3_mfg_pkg.sv
package ds3_mfg_pkg;
  localparam int unsigned PAY_LEN = 84;
  localparam int unsigned BLK_N   = 8;
  localparam int unsigned SUB_N   = 7;
  localparam int unsigned C_PER   = (BLK_N - 2) / 2;
  localparam int unsigned MF_LEN  = SUB_N * BLK_N * (PAY_LEN + 1);
  localparam logic [3:0]  F_PAT   = 4'b1001;  // F4..F1
  localparam logic [2:0]  M_PAT   = 3'b010;   // M3..M1
  typedef enum logic [1:0] {LEAD_X, LEAD_P, LEAD_M} lead_e;
endpackage

// File: rtl/ds3_pos_cnt.sv
module ds3_pos_cnt #(
  parameter int unsigned PAY_LEN = 84,
  parameter int unsigned BLK_N   = 8,
  parameter int unsigned SUB_N   = 7,
  localparam int unsigned BIT_W  = $clog2(PAY_LEN + 1),
  localparam int unsigned BLK_W  = $clog2(BLK_N),
  localparam int unsigned SUB_W  = $clog2(SUB_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [SUB_W-1:0] sub_o,
  output logic [BLK_W-1:0] blk_o,
  output logic             is_oh_o,
  output logic             mf_first_o,
  output logic             mf_last_o
);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(PAY_LEN);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(BLK_N - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_N - 1);

  logic [BIT_W-1:0] bit_q;
  logic [BLK_W-1:0] blk_q;
  logic [SUB_W-1:0] sub_q;
  logic             blk_end, sub_end;

  assign blk_end = (bit_q == BIT_LAST);
  assign sub_end = blk_end && (blk_q == BLK_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      blk_q <= '0;
      sub_q <= '0;
    end else begin
      bit_q <= blk_end ? '0 : bit_q + 1'b1;
      if (blk_end) blk_q <= (blk_q == BLK_LAST) ? '0 : blk_q + 1'b1;
      if (sub_end) sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
    end
  end

  assign sub_o      = sub_q;
  assign blk_o      = blk_q;
  assign is_oh_o    = (bit_q == '0);
  assign mf_first_o = is_oh_o && (blk_q == '0) && (sub_q == '0);
  assign mf_last_o  = sub_end && (sub_q == SUB_LAST);
endmodule

// File: rtl/ds3_oh_sel.sv
module ds3_oh_sel
  import ds3_mfg_pkg::*;
#(
  parameter int unsigned BLK_N  = 8,
  parameter int unsigned SUB_N  = 7,
  localparam int unsigned BLK_W = $clog2(BLK_N),
  localparam int unsigned SUB_W = $clog2(SUB_N),
  localparam int unsigned CB_W  = SUB_N * ((BLK_N - 2) / 2),
  localparam int unsigned CI_W  = $clog2(CB_W)
) (
  input  logic [SUB_W-1:0] sub_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic             alarm_i,
  input  logic             par_i,
  input  logic [CB_W-1:0]  c_bits_i,
  output logic             oh_bit_o
);
  localparam int unsigned CPS = (BLK_N - 2) / 2;

  lead_e             lead_kind;
  logic              lead_bit;
  logic [CI_W-1:0]   c_idx;
  logic [BLK_W-2:0]  pair;

  assign pair  = blk_i[BLK_W-1:1];
  assign c_idx = CI_W'(int'(sub_i) * CPS + int'(pair) - 1);

  always_comb begin
    if (sub_i < SUB_W'(2))      lead_kind = LEAD_X;
    else if (sub_i < SUB_W'(4)) lead_kind = LEAD_P;
    else                        lead_kind = LEAD_M;
  end

  always_comb begin
    unique case (lead_kind)
      LEAD_X:  lead_bit = ~alarm_i;
      LEAD_P:  lead_bit = par_i;
      default: lead_bit = M_PAT[2'(sub_i - SUB_W'(4))];
    endcase
  end

  always_comb begin
    if (blk_i == '0)    oh_bit_o = lead_bit;
    else if (blk_i[0])  oh_bit_o = F_PAT[pair];
    else                oh_bit_o = c_bits_i[c_idx];
  end
endmodule

// File: rtl/ds3_par_acc.sv
module ds3_par_acc (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic bit_i,
  input  logic mf_last_i,
  output logic par_o
);
  logic acc_q, par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= 1'b0;
      par_q <= 1'b0;
    end else if (mf_last_i) begin
      par_q <= acc_q ^ bit_i;
      acc_q <= 1'b0;
    end else if (take_i) begin
      acc_q <= acc_q ^ bit_i;
    end
  end

  assign par_o = par_q;
endmodule

// File: rtl/ds3_nib_trk.sv
module ds3_nib_trk #(
  parameter int unsigned NIB_LEN = 4,
  localparam int unsigned PH_W   = $clog2(NIB_LEN)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic is_oh_i,
  input  logic nib_en_i,
  output logic nib_o
);
  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ph_q <= '0;
    else if (is_oh_i) ph_q <= '0;
    else              ph_q <= (ph_q == PH_W'(NIB_LEN - 1)) ? '0 : ph_q + 1'b1;
  end

  assign nib_o = nib_en_i && !is_oh_i && (ph_q == '0);
endmodule

// File: rtl/ds3_mframe_gen.sv
module ds3_mframe_gen
  import ds3_mfg_pkg::*;
#(
  parameter int unsigned P_PAY_LEN = PAY_LEN,
  parameter int unsigned P_BLK_N   = BLK_N,
  parameter int unsigned P_SUB_N   = SUB_N,
  localparam int unsigned BLK_W    = $clog2(P_BLK_N),
  localparam int unsigned SUB_W    = $clog2(P_SUB_N),
  localparam int unsigned CB_W     = P_SUB_N * ((P_BLK_N - 2) / 2)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pay_bit_i,
  input  logic            alarm_i,
  input  logic [CB_W-1:0] c_bits_i,
  input  logic            nib_align_i,
  input  logic            plcp_i,
  output logic            ser_o,
  output logic            sof_o,
  output logic            pay_req_o,
  output logic            nib_o
);
  logic [SUB_W-1:0] sub;
  logic [BLK_W-1:0] blk;
  logic is_oh, mf_first, mf_last, par, oh_bit;
  logic ser_q, sof_q;

  ds3_pos_cnt #(.PAY_LEN(P_PAY_LEN), .BLK_N(P_BLK_N), .SUB_N(P_SUB_N)) u_pos (
    .clk_i, .rst_ni, .sub_o(sub), .blk_o(blk), .is_oh_o(is_oh),
    .mf_first_o(mf_first), .mf_last_o(mf_last)
  );

  ds3_oh_sel #(.BLK_N(P_BLK_N), .SUB_N(P_SUB_N)) u_oh (
    .sub_i(sub), .blk_i(blk), .alarm_i, .par_i(par), .c_bits_i, .oh_bit_o(oh_bit)
  );

  ds3_par_acc u_par (
    .clk_i, .rst_ni, .take_i(!is_oh), .bit_i(pay_bit_i),
    .mf_last_i(mf_last), .par_o(par)
  );

  // convergence-frame mode forces nibble alignment
  ds3_nib_trk #(.NIB_LEN(4)) u_nib (
    .clk_i, .rst_ni, .is_oh_i(is_oh), .nib_en_i(plcp_i | nib_align_i), .nib_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ser_q <= 1'b0;
      sof_q <= 1'b0;
    end else begin
      ser_q <= is_oh ? oh_bit : pay_bit_i;
      sof_q <= mf_first;
    end
  end

  assign ser_o     = ser_q;
  assign sof_o     = sof_q;
  assign pay_req_o = !is_oh;
endmodule

// File: rtl/ds3_mframe_gen_chk.sv
module ds3_mframe_gen_chk
  import ds3_mfg_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic sof_o,
  input logic pay_req_o,
  input logic nib_o,
  input logic nib_align_i,
  input logic plcp_i
);
  logic [$clog2(MF_LEN+1)-1:0] gap_q;
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (sof_o) begin
      gap_q  <= 1;
      seen_q <= 1'b1;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R1
  sof_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sof_o && seen_q) |-> (gap_q == MF_LEN));

  // R1
  sof_after_oh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> !$past(pay_req_o));

  // R2
  oh_then_pay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pay_req_o |=> pay_req_o);

  // R8
  nib_in_pay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_o |-> pay_req_o);

  // R8
  nib_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nib_align_i && !plcp_i) |-> !nib_o);
endmodule

bind ds3_mframe_gen ds3_mframe_gen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sof_o(sof_o), .pay_req_o(pay_req_o),
  .nib_o(nib_o), .nib_align_i(nib_align_i), .plcp_i(plcp_i)
);

// File: tb/ds3_mframe_gen_tb.sv
`timescale 1ns/1ps
module ds3_mframe_gen_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic pay_bit_i = 1'b0, alarm_i = 1'b0, nib_align_i = 1'b0, plcp_i = 1'b0;
  logic [20:0] c_bits_i = '0;
  logic ser_o, sof_o, pay_req_o, nib_o;

  int total = 0, bad = 0;
  int m_sub, m_blk, m_bit, mf_n;
  bit m_acc, m_par, prv_v, prv_bit, prv_sof;
  string prv_tag;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  ds3_mframe_gen u_dut (.*);

  function automatic bit exp_oh(int s, int b, bit al, logic [20:0] cb, bit par);
    if (b == 0) begin
      if (s < 2) return !al;
      if (s < 4) return par;
      return (s == 5);
    end
    if (b % 2 == 1) return (b == 1 || b == 7);
    return cb[s*3 + b/2 - 1];
  endfunction

  function automatic string oh_tag(int s, int b);
    if (b == 0) return (s == 2 || s == 3) ? "R3/R6" : "R3/R5";
    return (b % 2 == 1) ? "R3/R4" : "R3/R7";
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_sub = 0; m_blk = 0; m_bit = 0; m_acc = 0; m_par = 0; prv_v = 0;
  endtask

  // called at a falling edge; returns at the next one
  task automatic step();
    bit req, nib, b, ebit, last;
    if (prv_v) begin
      chk(ser_o === prv_bit, {prv_tag, "/R10"}, ser_o, prv_bit);
      chk(sof_o === prv_sof, "R1", sof_o, prv_sof);
    end
    if (m_bit == 0 && m_blk == 0) begin
      alarm_i  = $urandom_range(1);
      c_bits_i = 21'($urandom);
      if (m_sub == 0) begin
        nib_align_i = mf_n[0];
        plcp_i      = mf_n[1];
      end
    end
    req = (m_bit != 0);
    nib = req && (nib_align_i || plcp_i) && ((m_bit - 1) % 4 == 0);
    chk(pay_req_o === req, "R2", pay_req_o, req);
    chk(nib_o === nib, "R8", nib_o, nib);
    b = (mf_n == 0) ? 1'b0 : (mf_n == 1) ? 1'b1 : 1'($urandom);
    pay_bit_i = b;
    ebit = req ? b : exp_oh(m_sub, m_blk, alarm_i, c_bits_i, m_par);
    prv_tag = req ? "R10" : oh_tag(m_sub, m_blk);
    prv_bit = ebit;
    prv_sof = (m_sub == 0 && m_blk == 0 && m_bit == 0);
    prv_v = 1;
    last = (m_sub == 6 && m_blk == 7 && m_bit == 84);
    if (req) m_acc ^= b;
    if (last) begin m_par = m_acc; m_acc = 0; mf_n++; end
    if (m_bit == 84) begin
      m_bit = 0;
      if (m_blk == 7) begin m_blk = 0; m_sub = (m_sub == 6) ? 0 : m_sub + 1; end
      else m_blk++;
    end else m_bit++;
    @(negedge clk_i);
  endtask

  task automatic chk_reset_state();
    chk(ser_o === 1'b0, "R9", ser_o, 0);
    chk(sof_o === 1'b0, "R9", sof_o, 0);
    chk(pay_req_o === 1'b0, "R9", pay_req_o, 0);
    chk(nib_o === 1'b0, "R9", nib_o, 0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    mf_n = 0;
    repeat (3) @(negedge clk_i);
    chk_reset_state();
    rst_ni = 1'b1;
    model_reset();
    for (int i = 0; i < 4760 * 3 + 1000; i++) step();
    // mid-frame reset: counters and stored parity return to start
    rst_ni = 1'b0;
    #1;
    chk_reset_state();
    nib_align_i = 1'b1;
    plcp_i = 1'b1;
    @(negedge clk_i);
    chk_reset_state();
    rst_ni = 1'b1;
    model_reset();
    mf_n = 2;
    for (int i = 0; i < 4760 * 3 + 10; i++) step();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule